// File: doc/BRIEF.md
# Bus Address Decoder with Transfer Acknowledge

This block is the glue logic between a 16-bit asynchronous microprocessor bus and the memories and peripherals behind it. It watches the word address lines (bits 23 down to 1), the address strobe, the read/write line and the two byte data strobes. From these it produces one active-low chip select for each device in a fixed memory map, byte-lane write enables for the two RAMs, an output enable for the ROM, up to sixteen register selects inside the peripheral window, and an active-low transfer acknowledge back to the processor.

The map holds user RAM in the lowest 2 MB, ROM in the next 2 MB, a 1 MB peripheral window and a 1 MB stack RAM at the top of the 16 MB space. Everything between $400000 and $DFFFFF is left unmapped, so an access there gets no select and no acknowledge, and an external timer can raise a bus error. All outputs are combinational: a select and the acknowledge follow the strobe with no clocked delay.

Top module: `bus_addr_decoder`

## Requirements
- R1: While as_n is high (1), every chip select, register select, write enable, the ROM output enable and dtack_n are all high.
- R2: With as_n low, uram_cs_n is low exactly when address bits 23..21 are 000 (byte addresses $000000 to $1FFFFF).
- R3: With as_n low, rom_cs_n is low exactly when address bits 23..21 are 001 ($200000 to $3FFFFF), and rom_oe_n equals rom_cs_n on both reads and writes.
- R4: With as_n low, io_cs_n is low exactly when bits 23..20 are 1110 ($E00000 to $EFFFFF), and stk_cs_n is low exactly when bits 23..20 are 1111 ($F00000 to $FFFFFF).
- R5: Any address from $400000 to $DFFFFF asserts no chip select, no register select and no write enable.
- R6: At most one of uram_cs_n, rom_cs_n, io_cs_n and stk_cs_n is low at any time.
- R7: While io_cs_n is low, exactly the bit ioreg_sel_n[k] is low, where k is the value of address bits 4..1, so registers sit 2 bytes apart from $E00000; bits 19..5 are ignored, so the registers repeat throughout the window. With io_cs_n high all register selects are high.
- R8: dtack_n is low exactly when one of the four chip selects is low; an unmapped address never gets an acknowledge.
- R9: For each RAM, the upper-byte write enable is low only when that RAM's select is low, rw is 0 and uds_n is 0; the lower-byte write enable likewise with lds_n. A read (rw = 1) asserts no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 23 | Word address, bits 23..1 |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| uds_n | input | 1 | Upper byte data strobe, active low |
| lds_n | input | 1 | Lower byte data strobe, active low |
| uram_cs_n | output | 1 | User RAM select |
| uram_we_hi_n | output | 1 | User RAM upper byte write enable |
| uram_we_lo_n | output | 1 | User RAM lower byte write enable |
| rom_cs_n | output | 1 | ROM select |
| rom_oe_n | output | 1 | ROM output enable |
| stk_cs_n | output | 1 | Stack RAM select |
| stk_we_hi_n | output | 1 | Stack RAM upper byte write enable |
| stk_we_lo_n | output | 1 | Stack RAM lower byte write enable |
| io_cs_n | output | 1 | Peripheral window select |
| ioreg_sel_n | output | 16 | Per-register selects in the peripheral window |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The assertions hold on every evaluation the strobe gating, the mutual exclusion of the four device selects, the single register select confined to the peripheral window, the ROM enable tracking its decoded range, the absence of an acknowledge outside the map and the absence of write enables on reads. Whether each region starts and ends on exactly the right address, that bits 19..5 alias the register bank and that each byte lane answers to its own strobe can only be shown by the bench driving the boundary addresses, alias addresses and strobe combinations and comparing against its model.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

    localparam int ADDR_W  = 24;
    localparam int NUM_RGN = 4;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_URAM,
        RGN_ROM,
        RGN_IO,
        RGN_STK
    } region_e;

    // A window matches when (byte address & mask) == base.
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
    } rgn_win_t;

    function automatic rgn_win_t rgn_win(input int idx);
        rgn_win_t w;
        case (idx)
            0:       begin w.base = 24'h000000; w.mask = 24'hE00000; end
            1:       begin w.base = 24'h200000; w.mask = 24'hE00000; end
            2:       begin w.base = 24'hE00000; w.mask = 24'hF00000; end
            default: begin w.base = 24'hF00000; w.mask = 24'hF00000; end
        endcase
        return w;
    endfunction

    function automatic region_e rgn_id(input int idx);
        case (idx)
            0:       return RGN_URAM;
            1:       return RGN_ROM;
            2:       return RGN_IO;
            default: return RGN_STK;
        endcase
    endfunction

endpackage

// File: rtl/bus_rgn_classify.sv
module bus_rgn_classify
    import bus_dec_pkg::*;
(
    input  logic [ADDR_W-1:1] addr,
    input  logic              as_n,
    output region_e           rgn
);
    logic [ADDR_W-1:0]  byte_addr;
    logic [NUM_RGN-1:0] hit;

    assign byte_addr = {addr, 1'b0};

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_win
        localparam rgn_win_t WIN = rgn_win(g);
        assign hit[g] = !as_n && ((byte_addr & WIN.mask) == WIN.base);
    end

    always_comb begin
        rgn = RGN_NONE;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (hit[i]) rgn = rgn_id(i);
        end
    end
endmodule

// File: rtl/bus_reg_select.sv
module bus_reg_select #(
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             win_act,
    input  logic [IDX_W-1:0] idx,
    output logic [NUM_REGS-1:0] sel_n
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign sel_n[g] = !(win_act && (idx == IDX_W'(g)));
    end
endmodule

// File: rtl/bus_lane_write.sv
module bus_lane_write (
    input  logic cs_n,
    input  logic rw,
    input  logic uds_n,
    input  logic lds_n,
    output logic we_hi_n,
    output logic we_lo_n
);
    logic wr_ok;
    assign wr_ok   = !cs_n && !rw;
    assign we_hi_n = !(wr_ok && !uds_n);
    assign we_lo_n = !(wr_ok && !lds_n);
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
    import bus_dec_pkg::*;
#(
    parameter int NUM_IO_REGS = 16,
    localparam int IDX_W      = $clog2(NUM_IO_REGS)
) (
    input  logic [ADDR_W-1:1]      addr,
    input  logic                   as_n,
    input  logic                   rw,
    input  logic                   uds_n,
    input  logic                   lds_n,
    output logic                   uram_cs_n,
    output logic                   uram_we_hi_n,
    output logic                   uram_we_lo_n,
    output logic                   rom_cs_n,
    output logic                   rom_oe_n,
    output logic                   stk_cs_n,
    output logic                   stk_we_hi_n,
    output logic                   stk_we_lo_n,
    output logic                   io_cs_n,
    output logic [NUM_IO_REGS-1:0] ioreg_sel_n,
    output logic                   dtack_n
);
    region_e rgn;

    bus_rgn_classify u_cls (
        .addr (addr),
        .as_n (as_n),
        .rgn  (rgn)
    );

    assign uram_cs_n = (rgn != RGN_URAM);
    assign rom_cs_n  = (rgn != RGN_ROM);
    assign io_cs_n   = (rgn != RGN_IO);
    assign stk_cs_n  = (rgn != RGN_STK);

    // Read-only device: output enable tracks the select.
    assign rom_oe_n  = rom_cs_n;

    // Fast targets: acknowledge as soon as any device is selected.
    assign dtack_n   = (rgn == RGN_NONE);

    bus_reg_select #(.NUM_REGS(NUM_IO_REGS)) u_regs (
        .win_act (rgn == RGN_IO),
        .idx     (addr[IDX_W:1]),
        .sel_n   (ioreg_sel_n)
    );

    bus_lane_write u_uram_wr (
        .cs_n    (uram_cs_n),
        .rw      (rw),
        .uds_n   (uds_n),
        .lds_n   (lds_n),
        .we_hi_n (uram_we_hi_n),
        .we_lo_n (uram_we_lo_n)
    );

    bus_lane_write u_stk_wr (
        .cs_n    (stk_cs_n),
        .rw      (rw),
        .uds_n   (uds_n),
        .lds_n   (lds_n),
        .we_hi_n (stk_we_hi_n),
        .we_lo_n (stk_we_lo_n)
    );
endmodule

// File: rtl/bus_dec_chk.sv
module bus_dec_chk #(
    parameter int NUM_IO_REGS = 16
) (
    input logic [23:1]            addr,
    input logic                   as_n,
    input logic                   rw,
    input logic                   uds_n,
    input logic                   lds_n,
    input logic                   uram_cs_n,
    input logic                   uram_we_hi_n,
    input logic                   uram_we_lo_n,
    input logic                   rom_cs_n,
    input logic                   rom_oe_n,
    input logic                   stk_cs_n,
    input logic                   stk_we_hi_n,
    input logic                   stk_we_lo_n,
    input logic                   io_cs_n,
    input logic [NUM_IO_REGS-1:0] ioreg_sel_n,
    input logic                   dtack_n
);
    logic [3:0] dev_on;
    logic [3:0] we_on;
    logic       in_gap;
    logic       rom_range;

    assign dev_on    = ~{uram_cs_n, rom_cs_n, io_cs_n, stk_cs_n};
    assign we_on     = ~{uram_we_hi_n, uram_we_lo_n, stk_we_hi_n, stk_we_lo_n};
    assign in_gap    = (addr[23:21] != 3'b000) && (addr[23:21] != 3'b001) && (addr[23:21] != 3'b111);
    assign rom_range = !as_n && (addr[23:21] == 3'b001);

    always_comb begin
        AST_STROBE_GATE: assert (!as_n || (dev_on == 4'b0 && &ioreg_sel_n && we_on == 4'b0 && dtack_n && rom_oe_n)) else $error("strobe gate"); // R1
        AST_ROM_OE_RANGE: assert (rom_oe_n == !rom_range) else $error("rom oe"); // R3
        AST_GAP_SILENT: assert (!in_gap || (dev_on == 4'b0 && &ioreg_sel_n && we_on == 4'b0)) else $error("gap"); // R5
        AST_ONE_DEVICE: assert ($countones(dev_on) <= 1) else $error("multi select"); // R6
        AST_REG_IN_WINDOW: assert ($countones(~ioreg_sel_n) == (io_cs_n ? 0 : 1)) else $error("reg select"); // R7
        AST_NO_ACK_UNMAPPED: assert (dtack_n == (dev_on == 4'b0)) else $error("dtack"); // R8
        AST_NO_WRITE_ON_READ: assert (!rw || we_on == 4'b0) else $error("write on read"); // R9
    end
endmodule

bind bus_addr_decoder bus_dec_chk #(.NUM_IO_REGS(NUM_IO_REGS)) u_chk (
    .addr         (addr),
    .as_n         (as_n),
    .rw           (rw),
    .uds_n        (uds_n),
    .lds_n        (lds_n),
    .uram_cs_n    (uram_cs_n),
    .uram_we_hi_n (uram_we_hi_n),
    .uram_we_lo_n (uram_we_lo_n),
    .rom_cs_n     (rom_cs_n),
    .rom_oe_n     (rom_oe_n),
    .stk_cs_n     (stk_cs_n),
    .stk_we_hi_n  (stk_we_hi_n),
    .stk_we_lo_n  (stk_we_lo_n),
    .io_cs_n      (io_cs_n),
    .ioreg_sel_n  (ioreg_sel_n),
    .dtack_n      (dtack_n)
);

// File: tb/sim_bus_addr_decoder.sv
module sim_bus_addr_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:1] addr = '0;
    logic        as_n = 1'b1, rw = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
    logic uram_cs_n, uram_we_hi_n, uram_we_lo_n, rom_cs_n, rom_oe_n;
    logic stk_cs_n, stk_we_hi_n, stk_we_lo_n, io_cs_n, dtack_n;
    logic [15:0] ioreg_sel_n;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    bus_addr_decoder u0 (
        .addr(addr), .as_n(as_n), .rw(rw), .uds_n(uds_n), .lds_n(lds_n),
        .uram_cs_n(uram_cs_n), .uram_we_hi_n(uram_we_hi_n), .uram_we_lo_n(uram_we_lo_n),
        .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n),
        .stk_cs_n(stk_cs_n), .stk_we_hi_n(stk_we_hi_n), .stk_we_lo_n(stk_we_lo_n),
        .io_cs_n(io_cs_n), .ioreg_sel_n(ioreg_sel_n), .dtack_n(dtack_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d addr=%06h: actual=%0h expected=%0h",
                     req, cyc, {addr, 1'b0}, act, exp);
        end
    endtask

    // Behavioural reference, evaluated on every clock from the current inputs.
    always @(negedge clk) begin
        if (!rst && !done) begin
            int a;
            bit act, ur, ro, io, st, wr;
            logic [15:0] regs;
            a   = int'({addr, 1'b0});
            act = !as_n;
            ur  = act && (a < 32'h200000);
            ro  = act && (a >= 32'h200000) && (a < 32'h400000);
            io  = act && (a >= 32'hE00000) && (a < 32'hF00000);
            st  = act && (a >= 32'hF00000);
            wr  = !rw;
            regs = 16'hFFFF;
            if (io) regs[(a / 2) % 16] = 1'b0;
            cyc++;
            check("R2 uram_cs_n", 32'(uram_cs_n), 32'(!ur));
            check("R3 rom_cs_n",  32'(rom_cs_n),  32'(!ro));
            check("R3 rom_oe_n",  32'(rom_oe_n),  32'(!ro));
            check("R4 io_cs_n",   32'(io_cs_n),   32'(!io));
            check("R4 stk_cs_n",  32'(stk_cs_n),  32'(!st));
            check("R7 ioreg_sel_n", 32'(ioreg_sel_n), 32'(regs));
            check("R8 dtack_n",   32'(dtack_n),   32'(!(ur || ro || io || st)));
            check("R9 uram_we_hi_n", 32'(uram_we_hi_n), 32'(!(ur && wr && !uds_n)));
            check("R9 uram_we_lo_n", 32'(uram_we_lo_n), 32'(!(ur && wr && !lds_n)));
            check("R9 stk_we_hi_n",  32'(stk_we_hi_n),  32'(!(st && wr && !uds_n)));
            check("R9 stk_we_lo_n",  32'(stk_we_lo_n),  32'(!(st && wr && !lds_n)));
            if (as_n) check("R1 all idle", 32'({uram_cs_n, rom_cs_n, io_cs_n, stk_cs_n, dtack_n, &ioreg_sel_n}), 32'h3F);
            if (act && a >= 32'h400000 && a < 32'hE00000)
                check("R5 gap silent", 32'({uram_cs_n, rom_cs_n, io_cs_n, stk_cs_n, dtack_n}), 32'h1F);
            check("R6 one device", 32'($countones({!uram_cs_n, !rom_cs_n, !io_cs_n, !stk_cs_n}) <= 1), 32'd1);
        end
    end

    task automatic drive(input int byte_a, input bit strobe, input bit r, input bit u, input bit l);
        @(posedge clk);
        addr  = 23'(byte_a >> 1);
        as_n  = !strobe;
        rw    = r;
        uds_n = !u;
        lds_n = !l;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1: strobe high across mapped regions
        drive(32'h000000, 0, 0, 1, 1);
        drive(32'h200000, 0, 1, 1, 1);
        drive(32'hE00004, 0, 0, 1, 1);
        drive(32'hF00000, 0, 0, 1, 1);
        // R2/R3 boundaries
        drive(32'h000000, 1, 1, 1, 1);
        drive(32'h1FFFFE, 1, 1, 1, 1);
        drive(32'h200000, 1, 1, 1, 1);
        drive(32'h3FFFFE, 1, 0, 1, 1);
        // R5 gap edges
        drive(32'h400000, 1, 1, 1, 1);
        drive(32'hDFFFFE, 1, 0, 1, 1);
        drive(32'h9ABCDE, 1, 1, 1, 1);
        // R4/R7 window, register stepping and aliasing
        for (int k = 0; k < 16; k++) drive(32'hE00000 + 2 * k, 1, 1, 1, 1);
        drive(32'hE7FFE4, 1, 1, 1, 1);
        drive(32'hEFFFFE, 1, 0, 1, 1);
        drive(32'hF00000, 1, 1, 1, 1);
        drive(32'hFFFFFE, 1, 1, 1, 1);
        // R9 byte lanes
        drive(32'h001234, 1, 0, 1, 0);
        drive(32'h001234, 1, 0, 0, 1);
        drive(32'h001234, 1, 1, 1, 1);
        drive(32'hF01234, 1, 0, 1, 0);
        drive(32'hF01234, 1, 0, 0, 1);
        drive(32'hF01234, 1, 0, 1, 1);
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom);
            drive(r & 32'hFFFFFE, ($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2);
        end
        @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule